// File: doc/BRIEF.md
# Fault Event Log with Interrupt Policy

This block is the evidence store of a bus monitor. Upstream detectors validate faults and present one record per fault channel: entry and exit times, peak value, burst count and context bits. The log captures each validated fault and tags it with its channel number, the span between entry and exit, and the configuration ID in force at capture. It keeps the records in a ring until the host collects them.

The host reads the oldest record word by word through a select/read port. It may remove that record only after it has read every word. When the ring is full, a policy input chooses what happens to a new record. In overwrite mode the oldest record is discarded. In freeze mode the new record is refused. Every record that is lost is counted.

The interrupt only tells the host that new evidence exists. Three trigger modes are available. When several faults are validated together, the lowest channel number is written first.

Top module: `fault_event_log`

## Requirements
- R1: A record is built from the fault inputs and stored. Its fields, packed from the least significant bit upward, are: channel index (2 bits), entry time (16), exit time (16), span (16), peak (12), burst count (8), context (4) and configuration ID (8). The configuration ID is taken from `cfg_id` in the capture cycle. Context bit 0 is 1 for awake and 0 for sleep, bit 1 is 1 for persistent and 0 for transient, and bits 3:2 hold the severity. A pulse on `ev_valid` seen at clock edge k raises `level` at edge k+1. Word w of the head record is bits [32w+31:32w], zero-padded above bit 81.
- R2: The span field equals exit time minus entry time, modulo 2^16.
- R3: Faults validated in the same cycle are each stored as a separate record, in ascending channel order, at one record per cycle.
- R4: A channel may re-assert while its earlier record is still waiting behind a lower channel. In that case the new record is dropped and counted, and the earlier record is kept.
- R5: `pop` removes the head record only if words 0, 1 and 2 have each been read with `rd_en` since the last removal. Otherwise `pop` has no effect. A select value of 3 or above reads as zero.
- R6: In freeze mode (`pol_overwrite`=0), a record arriving at a full log is refused and counted. The log keeps its oldest records.
- R7: In overwrite mode (`pol_overwrite`=1), a record arriving at a full log replaces the oldest record and is counted as a loss. `level` stays at DEPTH.
- R8: `drop_cnt` counts lost records and saturates at 255. A one-cycle `ack` clears it.
- R9: A record written in the same cycle as an accepted `pop` is stored without loss or duplication.
- R10: Mode 0 (first occurrence): `irq` rises when a record enters an empty log, and a write into a non-empty log does not raise it. `ack` clears it.
- R11: Mode 1 (every occurrence): `irq` rises on every stored record, is not cleared by `ack`, and falls when the log becomes empty.
- R12: Mode 2 (threshold): `irq` rises when `level` moves from below `irq_thresh` to at or above it. `ack` clears it, and a threshold of 0 never fires.
- R13: After reset, `level`, `drop_cnt`, `irq` and `rd_data` are zero. In mode 3, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 4 | One-cycle fault validation, one bit per channel |
| ev_enter_ts | input | 64 | Entry timestamps, 16 bits per channel |
| ev_exit_ts | input | 64 | Exit timestamps, 16 bits per channel |
| ev_peak | input | 48 | Peak values, 12 bits per channel |
| ev_count | input | 32 | Burst counts, 8 bits per channel |
| ev_ctx | input | 16 | Context bits, 4 per channel |
| cfg_id | input | 8 | Active configuration ID |
| pol_overwrite | input | 1 | Full policy: 1 overwrite, 0 freeze |
| irq_mode | input | 2 | Interrupt mode: 0 first, 1 every, 2 threshold, 3 off |
| irq_thresh | input | 4 | Level threshold for mode 2 |
| rd_en | input | 1 | Marks the selected word as read |
| rd_sel | input | 2 | Word select of the head record |
| rd_data | output | 32 | Selected word of the head record |
| pop | input | 1 | Remove head record |
| ack | input | 1 | Host acknowledge |
| irq | output | 1 | New-evidence interrupt |
| level | output | 4 | Stored record count |
| drop_cnt | output | 8 | Lost-record counter |

## Verification
The assertions check several invariants on every cycle:
- the arbiter grants at most one channel per cycle;
- a pop with an incomplete read leaves the level unchanged;
- a refused record in freeze mode leaves the loss counter non-zero;
- `ack` clears the counter;
- in every-occurrence mode `irq` is low whenever the log is empty, and in mode 3 it is always low;
- in first-occurrence mode `irq` only rises after an empty log.

Other behaviour only the bench's scenarios can show: record contents and their order under simultaneous faults, which record survives each full policy, the span wrap-around, counter saturation, the distinctions between interrupt modes, and a write coinciding with a pop.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

  localparam int CTX_W = 4;

  typedef enum logic [1:0] {
    IRQ_FIRST  = 2'd0,
    IRQ_EVERY  = 2'd1,
    IRQ_THRESH = 2'd2,
    IRQ_OFF    = 2'd3
  } irq_mode_e;

  // Elapsed time between entry and exit, wrapping at the timestamp width.
  function automatic logic [31:0] span(input logic [31:0] t_in, input logic [31:0] t_out);
    return t_out - t_in;
  endfunction

  // Saturating addition for loss counting.
  function automatic logic [31:0] sat_add(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] max);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, max}) ? max : s[31:0];
  endfunction

endpackage

// File: rtl/evlog_stage.sv
module evlog_stage #(
  parameter int NF    = 4,
  parameter int REC_W = 82
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NF-1:0]    valid,
  input  logic [REC_W-1:0] rec_in [NF],
  output logic [NF-1:0]    grant,
  output logic [NF-1:0]    collide,
  output logic             wr_en,
  output logic [REC_W-1:0] wr_rec
);

  logic [NF-1:0]    pend;
  logic [REC_W-1:0] hold [NF];

  // Fixed priority: lowest pending channel wins.
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NF; i++) begin
      if (pend[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    wr_rec = '0;
    for (int i = 0; i < NF; i++) begin
      if (grant[i]) wr_rec = hold[i];
    end
  end

  assign wr_en   = |grant;
  assign collide = valid & pend & ~grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (valid[i] && (!pend[i] || grant[i])) pend[i] <= 1'b1;
        else if (grant[i])                      pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NF; i++) begin
      if (valid[i] && (!pend[i] || grant[i])) hold[i] <= rec_in[i];
    end
  end

endmodule

// File: rtl/evlog_ring.sv
module evlog_ring #(
  parameter int DEPTH = 8,
  parameter int REC_W = 82,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REC_W-1:0] wr_rec,
  input  logic             pop_ok,
  input  logic             overwrite,
  output logic [REC_W-1:0] head_rec,
  output logic [LW-1:0]    level,
  output logic [LW-1:0]    level_nxt,
  output logic             stored,
  output logic             lost,
  output logic             head_bumped
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  logic [REC_W-1:0] mem [DEPTH];
  logic [PW-1:0]    head, tail;
  logic             full;

  assign full        = (level == FULL);
  assign lost        = wr_en && full && !pop_ok;
  assign stored      = wr_en && (!full || pop_ok || overwrite);
  assign head_bumped = lost && overwrite;
  assign head_rec    = mem[head];

  always_comb begin
    level_nxt = level;
    if (stored && !head_bumped) level_nxt = level_nxt + LW'(1);
    if (pop_ok)                 level_nxt = level_nxt - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
    end else begin
      if (stored)                head <= head;
      if (stored)                tail <= ptr_next(tail);
      if (pop_ok || head_bumped) head <= ptr_next(head);
      level <= level_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (stored) mem[tail] <= wr_rec;
  end

endmodule

// File: rtl/evlog_irq.sv
module evlog_irq #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [LW-1:0] thresh,
  input  logic          stored,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] level_nxt,
  input  logic          ack,
  output logic          irq
);

  import evlog_pkg::*;

  logic crossing;
  assign crossing = (thresh != '0) && (level < thresh) && (level_nxt >= thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      case (irq_mode_e'(mode))
        IRQ_FIRST: begin
          if (stored && level == '0) irq <= 1'b1;
          else if (ack)              irq <= 1'b0;
        end
        IRQ_EVERY: begin
          if (stored)                 irq <= 1'b1;
          else if (level_nxt == '0)   irq <= 1'b0;
        end
        IRQ_THRESH: begin
          if (crossing)  irq <= 1'b1;
          else if (ack)  irq <= 1'b0;
        end
        default: irq <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/fault_event_log.sv
module fault_event_log #(
  parameter int NF     = 4,
  parameter int DEPTH  = 8,
  parameter int TS_W   = 16,
  parameter int PK_W   = 12,
  parameter int CNT_W  = 8,
  parameter int CFG_W  = 8,
  parameter int DW     = 32,
  parameter int DROP_W = 8,
  localparam int CTX_W  = evlog_pkg::CTX_W,
  localparam int FID_W  = (NF > 1) ? $clog2(NF) : 1,
  localparam int REC_W  = FID_W + 3 * TS_W + PK_W + CNT_W + CTX_W + CFG_W,
  localparam int NWORDS = (REC_W + DW - 1) / DW,
  localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NF-1:0]         ev_valid,
  input  logic [NF*TS_W-1:0]    ev_enter_ts,
  input  logic [NF*TS_W-1:0]    ev_exit_ts,
  input  logic [NF*PK_W-1:0]    ev_peak,
  input  logic [NF*CNT_W-1:0]   ev_count,
  input  logic [NF*CTX_W-1:0]   ev_ctx,
  input  logic [CFG_W-1:0]      cfg_id,
  input  logic                  pol_overwrite,
  input  logic [1:0]            irq_mode,
  input  logic [LW-1:0]         irq_thresh,
  input  logic                  rd_en,
  input  logic [SEL_W-1:0]      rd_sel,
  output logic [DW-1:0]         rd_data,
  input  logic                  pop,
  input  logic                  ack,
  output logic                  irq,
  output logic [LW-1:0]         level,
  output logic [DROP_W-1:0]     drop_cnt
);

  import evlog_pkg::*;

  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  // Named internal events, brought out for the checker.
  logic [REC_W-1:0]  rec [NF];
  logic [NF-1:0]     grant, collide;
  logic              wr_en, stored, lost, head_bumped, pop_ok, rd_all;
  logic [REC_W-1:0]  wr_rec, head_rec;
  logic [LW-1:0]     level_nxt;
  logic [NWORDS-1:0] seen;
  logic [DROP_W:0]   drop_inc;

  for (genvar i = 0; i < NF; i++) begin : g_rec
    logic [TS_W-1:0] t_in, t_out, dur;
    assign t_in  = ev_enter_ts[i*TS_W +: TS_W];
    assign t_out = ev_exit_ts[i*TS_W +: TS_W];
    assign dur   = TS_W'(span(32'(t_in), 32'(t_out)));
    assign rec[i] = {cfg_id, ev_ctx[i*CTX_W +: CTX_W], ev_count[i*CNT_W +: CNT_W],
                     ev_peak[i*PK_W +: PK_W], dur, t_out, t_in, FID_W'(i)};
  end

  evlog_stage #(.NF(NF), .REC_W(REC_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .valid(ev_valid), .rec_in(rec),
    .grant(grant), .collide(collide), .wr_en(wr_en), .wr_rec(wr_rec)
  );

  evlog_ring #(.DEPTH(DEPTH), .REC_W(REC_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rec(wr_rec), .pop_ok(pop_ok),
    .overwrite(pol_overwrite), .head_rec(head_rec), .level(level),
    .level_nxt(level_nxt), .stored(stored), .lost(lost), .head_bumped(head_bumped)
  );

  evlog_irq #(.LW(LW)) u_irq (
    .clk(clk), .rst_n(rst_n), .mode(irq_mode), .thresh(irq_thresh), .stored(stored),
    .level(level), .level_nxt(level_nxt), .ack(ack), .irq(irq)
  );

  // Read gate: every word of the head must be read before it can be removed.
  assign rd_all = &seen;
  assign pop_ok = pop && (level != '0) && rd_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
    end else if (pop_ok || head_bumped) begin
      seen <= '0;
    end else if (rd_en && level != '0) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (rd_sel == SEL_W'(w)) seen[w] <= 1'b1;
      end
    end
  end

  always_comb begin
    logic [NWORDS*DW-1:0] padded;
    padded  = (NWORDS*DW)'(head_rec);
    rd_data = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (level != '0 && rd_sel == SEL_W'(w)) rd_data = padded[w*DW +: DW];
    end
  end

  // Loss accounting: ring losses plus stage collisions.
  always_comb begin
    drop_inc = (DROP_W+1)'(lost);
    for (int i = 0; i < NF; i++) drop_inc = drop_inc + (DROP_W+1)'(collide[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_cnt <= '0;
    end else if (ack) begin
      drop_cnt <= (drop_inc > (DROP_W+1)'(DROP_MAX)) ? DROP_MAX : drop_inc[DROP_W-1:0];
    end else begin
      drop_cnt <= DROP_W'(sat_add(32'(drop_cnt), 32'(drop_inc), 32'(DROP_MAX)));
    end
  end

endmodule

// File: rtl/evlog_checker.sv
module evlog_checker #(
  parameter int NF     = 4,
  parameter int DEPTH  = 8,
  parameter int LW     = 4,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NF-1:0]     grant,
  input logic              wr_en,
  input logic              pop,
  input logic              pop_ok,
  input logic              rd_all,
  input logic              ack,
  input logic              pol_overwrite,
  input logic [1:0]        irq_mode,
  input logic              irq,
  input logic [LW-1:0]     level,
  input logic [DROP_W:0]   drop_inc,
  input logic [DROP_W-1:0] drop_cnt
);

  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_pop_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rd_all && !wr_en) |=> (level == $past(level)));

  assert_freeze_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pol_overwrite && level == LW'(DEPTH) && wr_en && !pop_ok && !ack) |=> (drop_cnt != '0));

  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && drop_inc == '0) |=> (drop_cnt == '0));

  assert_first_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'd0 && $rose(irq)) |-> ($past(level) == '0));

  assert_every_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'd1 && level == '0) |-> !irq);

  assert_off_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'd3) |-> !irq);

endmodule

bind fault_event_log evlog_checker #(
  .NF(NF), .DEPTH(DEPTH), .LW(LW), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .wr_en(wr_en), .pop(pop), .pop_ok(pop_ok),
  .rd_all(rd_all), .ack(ack), .pol_overwrite(pol_overwrite), .irq_mode(irq_mode),
  .irq(irq), .level(level), .drop_inc(drop_inc), .drop_cnt(drop_cnt)
);

// File: tb/fault_event_log_bench.sv
module fault_event_log_bench;

  localparam int NF = 4;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ev_valid = '0;
  logic [63:0] ev_enter_ts, ev_exit_ts;
  logic [47:0] ev_peak;
  logic [31:0] ev_count;
  logic [15:0] ev_ctx;
  logic [7:0]  cfg_id = 8'h00;
  logic        pol_overwrite = 1'b0;
  logic [1:0]  irq_mode = 2'd3;
  logic [3:0]  irq_thresh = 4'd0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        pop = 1'b0;
  logic        ack = 1'b0;
  logic        irq;
  logic [3:0]  level;
  logic [7:0]  drop_cnt;

  logic [15:0] b_en [NF];
  logic [15:0] b_ex [NF];
  logic [11:0] b_pk [NF];
  logic [7:0]  b_ct [NF];
  logic [3:0]  b_cx [NF];

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      ev_enter_ts[i*16 +: 16] = b_en[i];
      ev_exit_ts[i*16 +: 16]  = b_ex[i];
      ev_peak[i*12 +: 12]     = b_pk[i];
      ev_count[i*8 +: 8]      = b_ct[i];
      ev_ctx[i*4 +: 4]        = b_cx[i];
    end
  end

  fault_event_log u_fault_event_log (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_enter_ts(ev_enter_ts),
    .ev_exit_ts(ev_exit_ts), .ev_peak(ev_peak), .ev_count(ev_count), .ev_ctx(ev_ctx),
    .cfg_id(cfg_id), .pol_overwrite(pol_overwrite), .irq_mode(irq_mode),
    .irq_thresh(irq_thresh), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .pop(pop), .ack(ack), .irq(irq), .level(level), .drop_cnt(drop_cnt)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [95:0] exp_q [$];
  int drop_exp = 0;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Record image assembled field by field, per R1 and R2.
  function automatic logic [95:0] mk(input int idx, input logic [15:0] en, input logic [15:0] ex,
                                     input logic [11:0] pk, input logic [7:0] ct,
                                     input logic [3:0] cx, input logic [7:0] cf);
    logic [95:0] r;
    logic [15:0] d;
    d = ex - en;
    r = '0;
    r[1:0]   = 2'(idx);
    r[17:2]  = en;
    r[33:18] = ex;
    r[49:34] = d;
    r[61:50] = pk;
    r[69:62] = ct;
    r[73:70] = cx;
    r[81:74] = cf;
    return r;
  endfunction

  function automatic logic [95:0] chan_rec(input int i);
    return mk(i, b_en[i], b_ex[i], b_pk[i], b_ct[i], b_cx[i], cfg_id);
  endfunction

  function automatic void model_push(input logic [95:0] r);
    if (exp_q.size() < DEPTH) exp_q.push_back(r);
    else if (pol_overwrite) begin
      void'(exp_q.pop_front());
      exp_q.push_back(r);
      drop_exp = (drop_exp < 255) ? drop_exp + 1 : 255;
    end else drop_exp = (drop_exp < 255) ? drop_exp + 1 : 255;
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ev(input int i, input logic [15:0] en, input logic [15:0] ex,
                        input logic [11:0] pk, input logic [7:0] ct, input logic [3:0] cx);
    b_en[i] = en; b_ex[i] = ex; b_pk[i] = pk; b_ct[i] = ct; b_cx[i] = cx;
  endtask

  task automatic fire(input logic [3:0] m);
    @(negedge clk);
    ev_valid = m;
    for (int i = 0; i < NF; i++) if (m[i]) model_push(chan_rec(i));
    @(negedge clk);
    ev_valid = '0;
    settle(NF + 1);
  endtask

  task automatic read_rec(input logic [95:0] e, input string tag);
    for (int w = 0; w < 3; w++) begin
      rd_en = 1'b1;
      rd_sel = 2'(w);
      #1;
      check(64'(rd_data), 64'(e[w*32 +: 32]), tag);
      @(negedge clk);
    end
    rd_en = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic take(input string tag);
    read_rec(exp_q[0], tag);
    do_pop();
    void'(exp_q.pop_front());
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    drop_exp = 0;
  endtask

  task automatic do_reset(input logic ovw, input logic [1:0] mode, input logic [3:0] thr);
    @(negedge clk);
    rst_n = 1'b0;
    pol_overwrite = ovw;
    irq_mode = mode;
    irq_thresh = thr;
    settle(3);
    rst_n = 1'b1;
    exp_q.delete();
    drop_exp = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NF; i++) set_ev(i, 16'h0, 16'h0, 12'h0, 8'h0, 4'h0);
    do_reset(1'b0, 2'd3, 4'd0);
    // R13 reset state
    check(64'(level), 0, "R13 level");
    check(64'(drop_cnt), 0, "R13 drop");
    check(64'(irq), 0, "R13 irq");
    check(64'(rd_data), 0, "R13 rd_data");

    // R1 latency and layout, R2 wrapped span
    cfg_id = 8'hA5;
    set_ev(2, 16'hFFF0, 16'h0010, 12'hABC, 8'h3C, 4'b1011);
    @(negedge clk);
    ev_valid = 4'b0100;
    @(negedge clk);
    ev_valid = '0;
    check(64'(level), 0, "R1 level after capture edge");
    @(negedge clk);
    check(64'(level), 1, "R1 level after write edge");
    exp_q.push_back(chan_rec(2));
    check(64'(exp_q[0][49:34]), 64'h20, "R2 expected span");
    rd_sel = 2'd1;
    #1;
    check(64'(rd_data[17:2]), 64'h0020, "R2 span field");
    rd_sel = 2'd3;
    #1;
    check(64'(rd_data), 0, "R5 select beyond record");
    take("R1 record words");
    check(64'(level), 0, "R1 emptied");

    // R3 priority order and one write per cycle
    set_ev(0, 16'h0100, 16'h0180, 12'h011, 8'h01, 4'h1);
    set_ev(2, 16'h0200, 16'h0290, 12'h022, 8'h02, 4'h6);
    set_ev(3, 16'h0300, 16'h03A0, 12'h033, 8'h03, 4'hF);
    @(negedge clk);
    ev_valid = 4'b1101;
    exp_q.push_back(chan_rec(0));
    exp_q.push_back(chan_rec(2));
    exp_q.push_back(chan_rec(3));
    @(negedge clk);
    ev_valid = '0;
    @(negedge clk);
    check(64'(level), 1, "R3 one record per cycle");
    settle(3);
    check(64'(level), 3, "R3 all stored");
    take("R3 first channel 0");
    take("R3 second channel 2");
    take("R3 third channel 3");

    // R5 incomplete read blocks pop
    fire(4'b0010);
    rd_en = 1'b1;
    rd_sel = 2'd0;
    @(negedge clk);
    rd_sel = 2'd1;
    @(negedge clk);
    rd_en = 1'b0;
    do_pop();
    check(64'(level), 1, "R5 pop ignored after partial read");
    take("R5 full read then pop");
    check(64'(level), 0, "R5 pop accepted");

    // R4 collision of a waiting channel
    set_ev(0, 16'h1000, 16'h1001, 12'h1, 8'h1, 4'h0);
    set_ev(1, 16'h2000, 16'h2002, 12'h2, 8'h2, 4'h0);
    @(negedge clk);
    ev_valid = 4'b0011;
    exp_q.push_back(chan_rec(0));
    exp_q.push_back(chan_rec(1));
    @(negedge clk);
    set_ev(1, 16'h3000, 16'h3003, 12'h3, 8'h3, 4'h0);
    ev_valid = 4'b0010;
    @(negedge clk);
    ev_valid = '0;
    settle(3);
    check(64'(drop_cnt), 1, "R4 collision counted");
    take("R4 channel 0");
    take("R4 earlier channel 1 kept");
    do_ack();
    check(64'(drop_cnt), 0, "R8 ack clears");

    // R9 write coinciding with accepted pop
    fire(4'b0001);
    read_rec(exp_q[0], "R9 head before");
    set_ev(3, 16'h4444, 16'h4555, 12'h444, 8'h44, 4'h4);
    ev_valid = 4'b1000;
    @(negedge clk);
    ev_valid = '0;
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    void'(exp_q.pop_front());
    exp_q.push_back(chan_rec(3));
    check(64'(level), 1, "R9 level unchanged");
    take("R9 new record intact");

    // R6 freeze policy
    do_reset(1'b0, 2'd3, 4'd0);
    for (int k = 0; k < DEPTH + 1; k++) begin
      set_ev(1, 16'(k), 16'(k + 5), 12'(k), 8'(k), 4'h2);
      fire(4'b0010);
    end
    check(64'(level), DEPTH, "R6 level full");
    check(64'(drop_cnt), 1, "R6 refusal counted");
    check(64'(exp_q[0][17:2]), 0, "R6 model oldest");
    read_rec(exp_q[0], "R6 oldest kept");
    // R8 saturation
    for (int k = 0; k < 260; k++) begin
      @(negedge clk);
      ev_valid = 4'b0001;
      @(negedge clk);
      ev_valid = '0;
    end
    settle(3);
    check(64'(drop_cnt), 255, "R8 saturates");
    do_ack();
    check(64'(drop_cnt), 0, "R8 cleared after saturation");

    // R7 overwrite policy
    do_reset(1'b1, 2'd3, 4'd0);
    for (int k = 0; k < DEPTH + 1; k++) begin
      set_ev(2, 16'(k), 16'(k + 9), 12'(k), 8'(k), 4'h3);
      fire(4'b0100);
    end
    check(64'(level), DEPTH, "R7 level stays full");
    check(64'(drop_cnt), 1, "R7 loss counted");
    check(64'(exp_q[0][17:2]), 1, "R7 model second oldest");
    take("R7 oldest replaced");

    // R10 first-occurrence mode
    do_reset(1'b0, 2'd0, 4'd0);
    check(64'(irq), 0, "R10 idle");
    fire(4'b0001);
    check(64'(irq), 1, "R10 raised on empty log");
    do_ack();
    check(64'(irq), 0, "R10 ack clears");
    fire(4'b0010);
    check(64'(irq), 0, "R10 no raise when non-empty");

    // R11 every-occurrence mode
    do_reset(1'b0, 2'd1, 4'd0);
    fire(4'b0100);
    check(64'(irq), 1, "R11 raised");
    do_ack();
    check(64'(irq), 1, "R11 ack ignored");
    take("R11 drain");
    check(64'(irq), 0, "R11 falls when empty");

    // R12 threshold mode
    do_reset(1'b0, 2'd2, 4'd3);
    fire(4'b0001);
    fire(4'b0001);
    check(64'(irq), 0, "R12 below threshold");
    fire(4'b0001);
    check(64'(irq), 1, "R12 crossing");
    do_ack();
    check(64'(irq), 0, "R12 ack clears");
    fire(4'b0001);
    check(64'(irq), 0, "R12 no new crossing");
    do_reset(1'b0, 2'd2, 4'd0);
    fire(4'b0001);
    check(64'(irq), 0, "R12 zero threshold silent");

    // Random phase, overwrite policy, interrupts off
    do_reset(1'b1, 2'd3, 4'd0);
    void'($urandom(32'h1F2E3D4C));
    for (int it = 0; it < 150; it++) begin
      logic [3:0] m;
      m = 4'($urandom_range(1, 15));
      cfg_id = 8'($urandom);
      for (int i = 0; i < NF; i++)
        set_ev(i, 16'($urandom), 16'($urandom), 12'($urandom), 8'($urandom), 4'($urandom));
      fire(m);
      check(64'(level), 64'(exp_q.size()), "R7 random level");
      check(64'(drop_cnt), 64'(drop_exp), "R8 random drops");
      check(64'(irq), 0, "R13 random irq off");
      if ($urandom_range(0, 2) == 0) begin
        int npop;
        npop = $urandom_range(1, 4);
        for (int p = 0; p < npop; p++) if (exp_q.size() > 0) take("R1 random record");
      end
      if ($urandom_range(0, 9) == 0) do_ack();
    end
    while (exp_q.size() > 0) take("R1 random drain");
    check(64'(level), 0, "R9 random drained");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule